// File: doc/BRIEF.md
# PHY Standalone Mode Controller

This block decides whether an Ethernet controller's integrated PHY works for the chip's own MAC or is lent to an external MAC over an MII-like port. After every propagated reset it runs a fixed-length configuration load period. At the end of that period it captures a permission bit from the loaded configuration word. From then on it watches a mode-request pin. When the bit is set and the pin goes high, the controller switches the MII to PHY role, stops the clock to the internal CSMA/MAC unit and marks the PCI unit as isolated. Entering the mode resets nothing.

The reset inputs are also filtered. A chip reset or an alternate reset takes effect only after the isolate input has stayed deasserted for a minimum number of consecutive clocks. Where each reset goes depends on the mode. In normal operation either reset clears all three units (PCI, CSMA, PHY) and restarts the configuration load. In standalone mode the alternate reset clears only PCI and CSMA and leaves the PHY running. When the mode-request pin drops, the controller waits in an exit state and flags that a full reset is pending. It stays there until a reset arrives. All asynchronous control pins pass through multi-stage synchronizers first.

Top module: `phy_sa_ctrl`

## Requirements
- R1: While `por_n` is low, `state_o` is 0 (RESET), `pci_rst`, `csma_rst` and `phy_rst` are 1, `csma_clk_en` is 1 and `mii_phy_role` is 0.
- R2: `mode_req`, `rst_n`, `alt_rst_n` and `isolate_n` act only after a two-flop synchronizer. A mode-request rise first shows in `state_o` on the third rising edge after it is driven.
- R3: The configuration load state (`state_o`=1) lasts exactly `LOAD_CYCLES` counting edges. With `rst_n` released between edges, `state_o` is still 1 after 6003 edges and is 2 (NORMAL) after 6004. NORMAL is entered only from the load state.
- R4: Standalone mode (`state_o`=3) is entered from NORMAL only if bit 4 of `ee_cfg_word` was 1 at the end of the load. With that bit 0, `mode_req` is ignored and `state_o` stays 2.
- R5: In standalone mode `mii_phy_role`=1, `mii_txd_oe`=0, `mii_rxd_oe`=1, `csma_clk_en`=0 and `pci_isolate`=1. In every other state `mii_phy_role`=0, `mii_txd_oe`=1, `mii_rxd_oe`=0, `csma_clk_en`=1 and `pci_isolate`=0.
- R6: Entering standalone mode asserts none of `pci_rst`, `csma_rst` or `phy_rst`.
- R7: A low `rst_n` or `alt_rst_n` reaches the units only once the synchronized `isolate_n` has been high for `ISO_MIN` (4) consecutive edges. A shorter high period does not let the reset through, and any low clears the count. With `rst_n` held low, `phy_rst` rises after the sixth edge following the rise of `isolate_n`.
- R8: In standalone mode a propagated alternate reset asserts `pci_rst` and `csma_rst`, keeps `phy_rst` at 0 and leaves `state_o` at 3.
- R9: In standalone mode a propagated `rst_n` asserts `phy_rst` and moves `state_o` to 0.
- R10: Dropping `mode_req` in standalone mode moves `state_o` to 4 (EXIT_PENDING) with `reset_pending`=1. The state holds until a propagated reset.
- R11: Outside standalone mode either propagated reset asserts all three unit resets and moves `state_o` to 0. RESET holds while a propagated reset is active and moves to 1 on the first edge without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset of the controller itself, active low, asynchronous |
| rst_n | input | 1 | Chip reset request, active low, asynchronous |
| alt_rst_n | input | 1 | Alternate reset request, active low, asynchronous |
| isolate_n | input | 1 | Isolate request, active low, asynchronous |
| mode_req | input | 1 | Standalone mode request pin, asynchronous |
| ee_cfg_word | input | CFG_W | Configuration word delivered by the load phase |
| mii_phy_role | output | 1 | 1 when the MII runs in PHY role |
| mii_txd_oe | output | 1 | Output enable for the transmit data pins |
| mii_rxd_oe | output | 1 | Output enable for the receive data pins |
| csma_clk_en | output | 1 | Clock enable for the CSMA/MAC unit |
| pci_isolate | output | 1 | PCI unit treated as isolated |
| pci_rst | output | 1 | Reset to the PCI unit |
| csma_rst | output | 1 | Reset to the CSMA/MAC unit |
| phy_rst | output | 1 | Reset to the PHY unit |
| reset_pending | output | 1 | A full reset is recommended after leaving standalone mode |
| state_o | output | 3 | Controller state: 0 RESET, 1 LOAD, 2 NORMAL, 3 STANDALONE, 4 EXIT_PENDING |

## Verification
The assertions check these on every cycle: the standalone output set, the absence of unit resets at mode entry, that a PHY reset in standalone mode always leads to RESET, and that unit resets outside RESET appear only with a satisfied isolate window. They also check that NORMAL is entered only from the load state and that the exit state is left only for RESET. Some things only the bench scenarios can show: the exact edge counts of the synchronizers, of the load period and of the isolate window, and the sweep over isolate pulse lengths around the four-cycle threshold. The same holds for ignoring the mode pin when the configuration bit is clear, and for the different reset paths in each mode.

// File: rtl/phy_sa_pkg.sv
package phy_sa_pkg;
   typedef enum logic [2:0] {
      ST_RESET   = 3'd0,
      ST_LOAD    = 3'd1,
      ST_NORMAL  = 3'd2,
      ST_SA      = 3'd3,
      ST_EXIT    = 3'd4
   } sa_state_e;
endpackage

// File: rtl/phy_sa_sync.sv
module phy_sa_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("phy_sa_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("phy_sa_sync: W must be at least 1");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) begin
            chain[s] <= RST_VAL;
         end else if (s == 0) begin
            chain[s] <= d;
         end else begin
            chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/phy_sa_run_cnt.sv
module phy_sa_run_cnt #(
   parameter int unsigned LIMIT = 4
) (
   input  logic clk,
   input  logic por_n,
   input  logic run,
   output logic done
);
   if (LIMIT < 1) begin : g_bad_limit
      $error("phy_sa_run_cnt: LIMIT must be at least 1");
   end

   localparam int unsigned CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   logic [CW-1:0] cnt;

   assign done = (cnt == LIM);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else if (!done) begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/phy_sa_fsm.sv
module phy_sa_fsm
   import phy_sa_pkg::*;
(
   input  logic      clk,
   input  logic      por_n,
   input  logic      rst_eff,
   input  logic      alt_eff,
   input  logic      mode_s,
   input  logic      load_done,
   input  logic      cfg_bit,
   output sa_state_e state,
   output logic      sa_en
);
   sa_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_RESET:  if (!(rst_eff || alt_eff)) nxt = ST_LOAD;
         ST_LOAD: begin
            if (rst_eff || alt_eff) nxt = ST_RESET;
            else if (load_done)     nxt = ST_NORMAL;
         end
         ST_NORMAL: begin
            if (rst_eff || alt_eff)   nxt = ST_RESET;
            else if (sa_en && mode_s) nxt = ST_SA;
         end
         ST_SA: begin
            if (rst_eff)      nxt = ST_RESET;
            else if (!mode_s) nxt = ST_EXIT;
         end
         ST_EXIT:   if (rst_eff || alt_eff) nxt = ST_RESET;
         default:   nxt = ST_RESET;
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state <= ST_RESET;
         sa_en <= 1'b0;
      end else begin
         state <= nxt;
         if (state == ST_LOAD && nxt == ST_NORMAL) sa_en <= cfg_bit;
      end
   end
endmodule

// File: rtl/phy_sa_rst_fan.sv
module phy_sa_rst_fan
   import phy_sa_pkg::*;
(
   input  sa_state_e state,
   input  logic      rst_eff,
   input  logic      alt_eff,
   output logic      pci_rst,
   output logic      csma_rst,
   output logic      phy_rst
);
   logic any_eff;
   assign any_eff = rst_eff || alt_eff;

   always_comb begin
      if (state == ST_SA) begin
         pci_rst  = any_eff;
         csma_rst = any_eff;
         phy_rst  = rst_eff;
      end else begin
         pci_rst  = any_eff || (state == ST_RESET);
         csma_rst = any_eff || (state == ST_RESET);
         phy_rst  = any_eff || (state == ST_RESET);
      end
   end
endmodule

// File: rtl/phy_sa_ctrl.sv
module phy_sa_ctrl
   import phy_sa_pkg::*;
#(
   parameter int unsigned CFG_W       = 16,
   parameter int unsigned SA_BIT      = 4,
   parameter int unsigned LOAD_CYCLES = 6000,
   parameter int unsigned ISO_MIN     = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             rst_n,
   input  logic             alt_rst_n,
   input  logic             isolate_n,
   input  logic             mode_req,
   input  logic [CFG_W-1:0] ee_cfg_word,
   output logic             mii_phy_role,
   output logic             mii_txd_oe,
   output logic             mii_rxd_oe,
   output logic             csma_clk_en,
   output logic             pci_isolate,
   output logic             pci_rst,
   output logic             csma_rst,
   output logic             phy_rst,
   output logic             reset_pending,
   output logic [2:0]       state_o
);
   if (SA_BIT >= CFG_W) begin : g_bad_bit
      $error("phy_sa_ctrl: SA_BIT outside configuration word");
   end

   localparam int unsigned NSYNC = 4;
   localparam logic [NSYNC-1:0] SYNC_RST = 4'b0011;

   logic [NSYNC-1:0] raw_in, syn;
   logic rst_s, alt_s, iso_s, mode_s;
   logic iso_ok, rst_eff, alt_eff, load_run, load_done, sa_en_q;
   logic unused_cfg;
   sa_state_e state;

   assign raw_in = {mode_req, isolate_n, alt_rst_n, rst_n};

   phy_sa_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk(clk), .por_n(por_n), .d(raw_in), .q(syn)
   );

   assign rst_s  = syn[0];
   assign alt_s  = syn[1];
   assign iso_s  = syn[2];
   assign mode_s = syn[3];

   phy_sa_run_cnt #(.LIMIT(ISO_MIN)) u_iso_cnt (
      .clk(clk), .por_n(por_n), .run(iso_s), .done(iso_ok)
   );

   assign rst_eff = !rst_s && iso_ok;
   assign alt_eff = !alt_s && iso_ok;

   assign load_run = (state == ST_LOAD) && !rst_eff && !alt_eff;

   phy_sa_run_cnt #(.LIMIT(LOAD_CYCLES)) u_load_cnt (
      .clk(clk), .por_n(por_n), .run(load_run), .done(load_done)
   );

   phy_sa_fsm u_fsm (
      .clk(clk), .por_n(por_n), .rst_eff(rst_eff), .alt_eff(alt_eff),
      .mode_s(mode_s), .load_done(load_done), .cfg_bit(ee_cfg_word[SA_BIT]),
      .state(state), .sa_en(sa_en_q)
   );

   assign unused_cfg = ^ee_cfg_word;

   phy_sa_rst_fan u_fan (
      .state(state), .rst_eff(rst_eff), .alt_eff(alt_eff),
      .pci_rst(pci_rst), .csma_rst(csma_rst), .phy_rst(phy_rst)
   );

   assign mii_phy_role  = (state == ST_SA);
   assign mii_txd_oe    = !mii_phy_role;
   assign mii_rxd_oe    = mii_phy_role;
   assign csma_clk_en   = !mii_phy_role;
   assign pci_isolate   = mii_phy_role;
   assign reset_pending = (state == ST_EXIT);
   assign state_o       = state;
endmodule

// File: rtl/phy_sa_ctrl_chk.sv
module phy_sa_ctrl_chk (
   input logic       clk,
   input logic       por_n,
   input logic [2:0] state_o,
   input logic       pci_rst,
   input logic       csma_rst,
   input logic       phy_rst,
   input logic       csma_clk_en,
   input logic       mii_phy_role,
   input logic       pci_isolate,
   input logic       iso_ok,
   input logic       sa_en
);
   a_r5_sa_outputs: assert property (@(posedge clk) disable iff (!por_n)
      state_o == 3'd3 |-> (!csma_clk_en && mii_phy_role && pci_isolate));

   a_r6_entry_quiet: assert property (@(posedge clk) disable iff (!por_n)
      (state_o == 3'd3 && $past(state_o) == 3'd2) |-> (!pci_rst && !csma_rst && !phy_rst));

   a_r4_entry_needs_cfg: assert property (@(posedge clk) disable iff (!por_n)
      state_o == 3'd3 |-> sa_en);

   a_r9_phy_rst_leaves_sa: assert property (@(posedge clk) disable iff (!por_n)
      (state_o == 3'd3 && phy_rst) |=> state_o == 3'd0);

   a_r7_gate_window: assert property (@(posedge clk) disable iff (!por_n)
      (state_o != 3'd0 && (pci_rst || csma_rst || phy_rst)) |-> iso_ok);

   a_r3_normal_from_load: assert property (@(posedge clk) disable iff (!por_n)
      (state_o == 3'd2 && $past(state_o) != 3'd2) |-> $past(state_o) == 3'd1);

   a_r10_exit_holds: assert property (@(posedge clk) disable iff (!por_n)
      state_o == 3'd4 |=> (state_o == 3'd4 || state_o == 3'd0));
endmodule

bind phy_sa_ctrl phy_sa_ctrl_chk u_chk (
   .clk(clk), .por_n(por_n), .state_o(state_o), .pci_rst(pci_rst),
   .csma_rst(csma_rst), .phy_rst(phy_rst), .csma_clk_en(csma_clk_en),
   .mii_phy_role(mii_phy_role), .pci_isolate(pci_isolate),
   .iso_ok(iso_ok), .sa_en(sa_en_q)
);

// File: tb/phy_sa_ctrl_tb_top.sv
`timescale 1ns/1ps
module phy_sa_ctrl_tb_top;
   localparam int LOAD = 6000;
   localparam int ISO  = 4;

   logic clk = 1'b0;
   logic por_n, rst_n, alt_rst_n, isolate_n, mode_req;
   logic [15:0] ee_cfg_word;
   logic mii_phy_role, mii_txd_oe, mii_rxd_oe, csma_clk_en, pci_isolate;
   logic pci_rst, csma_rst, phy_rst, reset_pending;
   logic [2:0] state_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #5 clk = ~clk;

   phy_sa_ctrl dut_i (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .alt_rst_n(alt_rst_n),
      .isolate_n(isolate_n), .mode_req(mode_req), .ee_cfg_word(ee_cfg_word),
      .mii_phy_role(mii_phy_role), .mii_txd_oe(mii_txd_oe), .mii_rxd_oe(mii_rxd_oe),
      .csma_clk_en(csma_clk_en), .pci_isolate(pci_isolate), .pci_rst(pci_rst),
      .csma_rst(csma_rst), .phy_rst(phy_rst), .reset_pending(reset_pending),
      .state_o(state_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk_role(input string req, input bit sa);
      chk({req, " role"}, int'(mii_phy_role), int'(sa));
      chk({req, " txd_oe"}, int'(mii_txd_oe), int'(!sa));
      chk({req, " rxd_oe"}, int'(mii_rxd_oe), int'(sa));
      chk({req, " csma_clk_en"}, int'(csma_clk_en), int'(!sa));
      chk({req, " pci_isolate"}, int'(pci_isolate), int'(sa));
   endtask

   // R11: reset pulse while isolate is released; then count the load period (R3)
   task automatic full_reset_exact();
      rst_n = 1'b0;
      step(8);
      chk("R11 reset state", int'(state_o), 0);
      chk("R11 all resets", int'({pci_rst, csma_rst, phy_rst}), 7);
      rst_n = 1'b1;
      step(LOAD + 3);
      chk("R3 still loading", int'(state_o), 1);
      step(1);
      chk("R3 normal after load", int'(state_o), 2);
   endtask

   task automatic wait_state(input int st, input string req);
      for (int i = 0; i < 7000; i++) begin
         if (state_o == 3'(st)) break;
         step(1);
      end
      chk(req, int'(state_o), st);
   endtask

   initial begin
      for (;;) begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
         end
      end
   end

   initial begin
      por_n = 1'b0; rst_n = 1'b1; alt_rst_n = 1'b1; isolate_n = 1'b1;
      mode_req = 1'b0; ee_cfg_word = 16'h0010;
      step(3);
      // R1
      chk("R1 state in por", int'(state_o), 0);
      chk("R1 resets in por", int'({pci_rst, csma_rst, phy_rst}), 7);
      chk_role("R1", 1'b0);
      por_n = 1'b1;
      step(1);
      chk("R11 leaves reset to load", int'(state_o), 1);
      wait_state(2, "R3 reach normal");
      chk_role("R5 normal", 1'b0);

      full_reset_exact();

      // R2, R5, R6: entry
      mode_req = 1'b1;
      step(2);
      chk("R2 not yet entered", int'(state_o), 2);
      step(1);
      chk("R2 entered on third edge", int'(state_o), 3);
      chk("R6 no reset at entry", int'({pci_rst, csma_rst, phy_rst}), 0);
      chk_role("R5 standalone", 1'b1);

      // R8: alternate reset in standalone mode
      alt_rst_n = 1'b0;
      step(3);
      chk("R8 pci_rst", int'(pci_rst), 1);
      chk("R8 csma_rst", int'(csma_rst), 1);
      chk("R8 phy untouched", int'(phy_rst), 0);
      chk("R8 state kept", int'(state_o), 3);
      alt_rst_n = 1'b1;
      step(3);
      chk("R8 released", int'({pci_rst, csma_rst, phy_rst}), 0);

      // R10: exit
      mode_req = 1'b0;
      step(3);
      chk("R10 exit state", int'(state_o), 4);
      chk("R10 reset pending", int'(reset_pending), 1);
      chk_role("R10 exit outputs", 1'b0);
      step(20);
      chk("R10 exit holds", int'(state_o), 4);

      // R4: configuration bit clear
      ee_cfg_word = 16'hFFEF;
      full_reset_exact();
      mode_req = 1'b1;
      step(10);
      chk("R4 pin ignored", int'(state_o), 2);
      chk("R4 clock kept", int'(csma_clk_en), 1);
      mode_req = 1'b0;

      // R9: chip reset in standalone mode
      ee_cfg_word = 16'h0010;
      full_reset_exact();
      mode_req = 1'b1;
      step(3);
      chk("R9 in standalone", int'(state_o), 3);
      rst_n = 1'b0;
      step(3);
      chk("R9 state reset", int'(state_o), 0);
      chk("R9 phy reset", int'(phy_rst), 1);
      mode_req = 1'b0;
      rst_n = 1'b1;
      wait_state(2, "R9 back to normal");

      // R11: alternate reset outside standalone mode
      alt_rst_n = 1'b0;
      step(3);
      chk("R11 alt resets state", int'(state_o), 0);
      chk("R11 alt resets phy", int'(phy_rst), 1);
      alt_rst_n = 1'b1;
      wait_state(2, "R11 reload");

      // R7: isolate window sweep
      isolate_n = 1'b0;
      step(4);
      rst_n = 1'b0;
      step(4);
      chk("R7 blocked while isolated", int'(phy_rst), 0);
      for (int len = 1; len <= 7; len++) begin
         bit seen = 1'b0;
         isolate_n = 1'b1;
         for (int i = 0; i < len; i++) begin
            step(1);
            seen |= phy_rst;
         end
         isolate_n = 1'b0;
         for (int i = 0; i < 10; i++) begin
            step(1);
            seen |= phy_rst;
         end
         chk($sformatf("R7 window len %0d", len), int'(seen), int'(len >= ISO));
      end
      isolate_n = 1'b1;
      step(ISO + 1);
      chk("R7 latency not yet", int'(phy_rst), 0);
      step(1);
      chk("R7 latency reached", int'(phy_rst), 1);
      rst_n = 1'b1;
      step(5);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule